// File: doc/BRIEF.md
# Complex-Gain Envelope Predistorter

This block sits in the transmit baseband path ahead of a power amplifier. Every clock it can accept one complex sample (signed in-phase and quadrature words). It approximates the envelope magnitude of that sample and maps the magnitude uniformly onto a table index. The index reads one complex correction coefficient, and the block multiplies the sample by that coefficient. Because a single complex gain scales and rotates the sample, one table corrects both compression and phase shift.

The coefficient table is filled through its own write port. This port stands for a training engine working off the signal path that copies fresh coefficients in from time to time. A write can land in any cycle, even while samples stream, and it never stops the one-sample-per-clock flow. The latency is fixed at three clocks. A valid flag travels alongside the data.

Top module: `cgp_predistorter`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_vld` is 0 and `out_i`/`out_q` are 0. Reset is synchronous and active high.
- R2: A sample presented with `in_vld`=1 in cycle n appears at the outputs with `out_vld`=1 in cycle n+3. An idle input cycle gives `out_vld`=0 three cycles later. A new sample is accepted every cycle.
- R3: The magnitude is m = max(|I|,|Q|) + floor(min(|I|,|Q|)/2). It is computed without a square root, and |−32768| counts as 32768. The table index is m >> 7 (the top 8 bits of a 15-bit magnitude range). When m ≥ 32768 the index saturates to 255 and does not wrap.
- R4: A coefficient is a signed Q2.14 pair (real, imaginary), so unity is (16384, 0). After every reset, all 256 entries read as unity until they are written, and the output then equals the input.
- R5: With coefficient (cr, ci), the outputs are out_i = sat((I·cr − Q·ci + 8192) >>> 14) and out_q = sat((I·ci + Q·cr + 8192) >>> 14). Here sat clamps to [−32768, 32767] and >>> is an arithmetic right shift.
- R6: A write (`cf_we`=1, `cf_addr`, `cf_re`, `cf_im`) presented in cycle c is used by samples presented in cycle c or later. A sample presented in cycle c−1 with the same index still gets the previous coefficient.
- R7: Table writes, including a write in every cycle, leave the output valid pattern and the latency unchanged.
- R8: While `out_vld` is 0, `out_i`/`out_q` hold the value of the last valid output, or 0 if there has been none since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input sample valid |
| in_i | input | 16 | Input in-phase, signed |
| in_q | input | 16 | Input quadrature, signed |
| cf_we | input | 1 | Coefficient write enable |
| cf_addr | input | 8 | Coefficient table index to write |
| cf_re | input | 16 | Coefficient real part, signed Q2.14 |
| cf_im | input | 16 | Coefficient imaginary part, signed Q2.14 |
| out_vld | output | 1 | Output sample valid |
| out_i | output | 16 | Corrected in-phase, signed |
| out_q | output | 16 | Corrected quadrature, signed |

## Verification
A coefficient write and a table read of the same index can fall in the same clock. In that case the sample being read must get the old coefficient, and the sample one cycle behind it must get the new one. The bench sets this up by presenting a sample of index 31 and, one cycle later, a write to entry 31 together with a second index-31 sample. It judges the result by the output values, because the old and new coefficients give clearly different products. During the full table load a write also arrives in every cycle alongside streaming samples. In that run the bench compares each output against a model updated in presentation order, and it checks that no valid slot is lost.

// File: rtl/cgp_pkg.sv
package cgp_pkg;
  // Default geometry of the predistorter datapath
  localparam int DEF_IQ_W   = 16;  // sample word width
  localparam int DEF_MAG_W  = 16;  // unsigned magnitude word width
  localparam int DEF_ADDR_W = 8;   // table index width (256 entries)
  localparam int DEF_CF_W   = 16;  // coefficient part width
  localparam int DEF_FRAC   = 14;  // coefficient fraction bits
endpackage

// File: rtl/cgp_mag_index.sv
module cgp_mag_index import cgp_pkg::*; #(
  parameter int IQ_W   = DEF_IQ_W,
  parameter int MAG_W  = DEF_MAG_W,
  parameter int ADDR_W = DEF_ADDR_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_vld,
  input  logic signed [IQ_W-1:0]   in_i,
  input  logic signed [IQ_W-1:0]   in_q,
  output logic                     s1_vld,
  output logic signed [IQ_W-1:0]   s1_i,
  output logic signed [IQ_W-1:0]   s1_q,
  output logic [ADDR_W-1:0]        s1_idx
);
  // Full scale of the index range is 2^(IQ_W-1); index takes the top ADDR_W bits
  localparam int SHIFT = IQ_W - 1 - ADDR_W;
  localparam logic [MAG_W:0]   MAG_MAX = {1'b0, {MAG_W{1'b1}}};
  localparam logic [MAG_W-1:0] FULL    = MAG_W'(1) << (IQ_W - 1);
  localparam logic signed [IQ_W-1:0] MOST_NEG = {1'b1, {(IQ_W-1){1'b0}}};

  logic [IQ_W-1:0]   abs_i, abs_q, big, sml;
  logic [MAG_W:0]    sum;
  logic [MAG_W-1:0]  mag;
  logic [ADDR_W-1:0] idx_c;

  // Two's complement negate: the most negative value maps to 2^(IQ_W-1) unsigned
  assign abs_i = in_i[IQ_W-1] ? IQ_W'(-in_i) : IQ_W'(in_i);
  assign abs_q = in_q[IQ_W-1] ? IQ_W'(-in_q) : IQ_W'(in_q);
  assign big   = (abs_i >= abs_q) ? abs_i : abs_q;
  assign sml   = (abs_i >= abs_q) ? abs_q : abs_i;
  assign sum   = (MAG_W+1)'(big) + (MAG_W+1)'(sml >> 1);
  assign mag   = (sum > MAG_MAX) ? MAG_MAX[MAG_W-1:0] : sum[MAG_W-1:0];
  assign idx_c = (mag >= FULL) ? {ADDR_W{1'b1}} : ADDR_W'(mag >> SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s1_i   <= '0;
      s1_q   <= '0;
      s1_idx <= '0;
    end else begin
      s1_vld <= in_vld;
      s1_i   <= in_i;
      s1_q   <= in_q;
      s1_idx <= idx_c;
    end
  end

  // R3: most negative in-phase input lies beyond full scale, so the top entry is used
  assert_idx_saturate_R3: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_i == MOST_NEG) |=> (s1_idx == {ADDR_W{1'b1}}));

  // R3: a zero sample addresses the first entry
  assert_idx_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_i == '0 && in_q == '0) |=> (s1_idx == '0));
endmodule

// File: rtl/cgp_coef_ram.sv
module cgp_coef_ram import cgp_pkg::*; #(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int CF_W   = DEF_CF_W,
  parameter int FRAC   = DEF_FRAC
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic signed [CF_W-1:0]   wr_re,
  input  logic signed [CF_W-1:0]   wr_im,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic signed [CF_W-1:0]   coef_re,
  output logic signed [CF_W-1:0]   coef_im
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int WW    = 2 * CF_W;
  localparam logic signed [CF_W-1:0] UNITY = CF_W'(64'sd1 <<< FRAC);

  // Storage without reset so it maps to block RAM; a flag array tracks written entries
  logic [WW-1:0]    mem [DEPTH];
  logic [WW-1:0]    rd_word;
  logic [DEPTH-1:0] written;
  logic             rd_hit;

  // Read-before-write: a same-cycle read of the written entry returns the old word
  always_ff @(posedge clk) begin
    if (wr_en && !rst) mem[wr_addr] <= {wr_re, wr_im};
    if (rd_en)         rd_word      <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written <= '0;
      rd_hit  <= 1'b0;
    end else begin
      if (wr_en) written[wr_addr] <= 1'b1;
      if (rd_en) rd_hit           <= written[rd_addr];
    end
  end

  assign coef_re = rd_hit ? rd_word[WW-1:CF_W] : UNITY;
  assign coef_im = rd_hit ? rd_word[CF_W-1:0]  : '0;

  // R6: a word written two cycles back and read one cycle back, with no newer write, is returned
  assert_write_visible_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && !$past(rst) && !$past(rst, 2) && $past(wr_en, 2) &&
     $past(wr_addr, 2) == $past(rd_addr) &&
     !($past(wr_en) && $past(wr_addr) == $past(rd_addr)))
    |-> (coef_re == $past(wr_re, 2) && coef_im == $past(wr_im, 2)));
endmodule

// File: rtl/cgp_cmul.sv
module cgp_cmul import cgp_pkg::*; #(
  parameter int IQ_W = DEF_IQ_W,
  parameter int CF_W = DEF_CF_W,
  parameter int FRAC = DEF_FRAC
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     vld,
  input  logic signed [IQ_W-1:0]   a_re,
  input  logic signed [IQ_W-1:0]   a_im,
  input  logic signed [CF_W-1:0]   c_re,
  input  logic signed [CF_W-1:0]   c_im,
  output logic                     y_vld,
  output logic signed [IQ_W-1:0]   y_re,
  output logic signed [IQ_W-1:0]   y_im
);
  localparam int PW = IQ_W + CF_W + 1;
  localparam logic signed [PW-1:0] HALF = PW'(64'sd1 <<< (FRAC - 1));
  localparam logic signed [PW-1:0] HI   = PW'((64'sd1 <<< (IQ_W - 1)) - 64'sd1);
  localparam logic signed [PW-1:0] LO   = PW'(-(64'sd1 <<< (IQ_W - 1)));
  localparam logic signed [IQ_W-1:0] OUT_HI = {1'b0, {(IQ_W-1){1'b1}}};
  localparam logic signed [IQ_W-1:0] OUT_LO = {1'b1, {(IQ_W-1){1'b0}}};

  logic signed [PW-1:0]   acc [2];
  logic signed [IQ_W-1:0] lim [2];

  assign acc[0] = PW'(a_re) * PW'(c_re) - PW'(a_im) * PW'(c_im);
  assign acc[1] = PW'(a_re) * PW'(c_im) + PW'(a_im) * PW'(c_re);

  // Same round-shift-clamp stage for both lanes
  for (genvar k = 0; k < 2; k++) begin : g_lane
    logic signed [PW-1:0] rnd, shf;
    assign rnd    = acc[k] + HALF;
    assign shf    = rnd >>> FRAC;
    assign lim[k] = (shf > HI) ? OUT_HI :
                    (shf < LO) ? OUT_LO : shf[IQ_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_vld <= 1'b0;
      y_re  <= '0;
      y_im  <= '0;
    end else begin
      y_vld <= vld;
      if (vld) begin
        y_re <= lim[0];
        y_im <= lim[1];
      end
    end
  end

  // R5: most negative sample times the largest positive gain clamps low
  assert_clamp_low_R5: assert property (@(posedge clk) disable iff (rst)
    (vld && a_re == OUT_LO && a_im == '0 && c_re == CF_W'(OUT_HI) && c_im == '0)
    |=> (y_re == OUT_LO && y_im == '0));

  // R8: outputs are frozen through invalid slots
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !vld |=> ($stable(y_re) && $stable(y_im)));
endmodule

// File: rtl/cgp_predistorter.sv
module cgp_predistorter import cgp_pkg::*; #(
  parameter int IQ_W   = DEF_IQ_W,
  parameter int MAG_W  = DEF_MAG_W,
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int CF_W   = DEF_CF_W,
  parameter int FRAC   = DEF_FRAC
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_vld,
  input  logic signed [IQ_W-1:0]   in_i,
  input  logic signed [IQ_W-1:0]   in_q,
  input  logic                     cf_we,
  input  logic [ADDR_W-1:0]        cf_addr,
  input  logic signed [CF_W-1:0]   cf_re,
  input  logic signed [CF_W-1:0]   cf_im,
  output logic                     out_vld,
  output logic signed [IQ_W-1:0]   out_i,
  output logic signed [IQ_W-1:0]   out_q
);
  localparam int LATENCY = 3;

  logic                    s1_vld, s2_vld;
  logic signed [IQ_W-1:0]  s1_i, s1_q, s2_i, s2_q;
  logic [ADDR_W-1:0]       s1_idx;
  logic signed [CF_W-1:0]  k_re, k_im;

  // Stage 1: envelope estimate and table index
  cgp_mag_index #(.IQ_W(IQ_W), .MAG_W(MAG_W), .ADDR_W(ADDR_W)) u_mag (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
    .s1_vld(s1_vld), .s1_i(s1_i), .s1_q(s1_q), .s1_idx(s1_idx)
  );

  // Stage 2: coefficient read, sample delayed alongside it
  cgp_coef_ram #(.ADDR_W(ADDR_W), .CF_W(CF_W), .FRAC(FRAC)) u_ram (
    .clk(clk), .rst(rst), .wr_en(cf_we), .wr_addr(cf_addr), .wr_re(cf_re),
    .wr_im(cf_im), .rd_en(s1_vld), .rd_addr(s1_idx), .coef_re(k_re), .coef_im(k_im)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_vld <= 1'b0;
      s2_i   <= '0;
      s2_q   <= '0;
    end else begin
      s2_vld <= s1_vld;
      s2_i   <= s1_i;
      s2_q   <= s1_q;
    end
  end

  // Stage 3: complex gain applied, registered outputs
  cgp_cmul #(.IQ_W(IQ_W), .CF_W(CF_W), .FRAC(FRAC)) u_mul (
    .clk(clk), .rst(rst), .vld(s2_vld), .a_re(s2_i), .a_im(s2_q),
    .c_re(k_re), .c_im(k_im), .y_vld(out_vld), .y_re(out_i), .y_im(out_q)
  );

  // Cycles since reset, saturating once the pipeline is fully refilled
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'(LATENCY)) since_rst <= since_rst + 2'd1;
  end

  // R2 / R7: output valid is the input valid three clocks earlier, writes or not
  assert_fixed_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'(LATENCY)) |-> (out_vld == $past(in_vld, 3)));

  // R1: first cycle out of reset shows an empty pipeline
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!out_vld && out_i == '0 && out_q == '0));
endmodule

// File: tb/cgp_predistorter_tb_top.sv
module cgp_predistorter_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic cf_we = 1'b0;
  logic [7:0] cf_addr = '0;
  logic signed [15:0] cf_re = '0, cf_im = '0;
  logic out_vld;
  logic signed [15:0] out_i, out_q;

  // 200 MHz clock
  always #2.5 clk = ~clk;

  cgp_predistorter dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
    .cf_we(cf_we), .cf_addr(cf_addr), .cf_re(cf_re), .cf_im(cf_im),
    .out_vld(out_vld), .out_i(out_i), .out_q(out_q)
  );

  // {I, Q, hand-derived table index per R3}
  localparam logic [39:0] VEC [16] = '{
    {16'sd0,      16'sd0,      8'd0},
    {16'sd1000,   16'sd0,      8'd7},
    {16'sd0,     -16'sd1000,   8'd7},
    {16'sd3000,   16'sd2000,   8'd31},
    {-16'sd2000,  16'sd3000,   8'd31},
    {16'sd10000, -16'sd10000,  8'd117},
    {-16'sd20000,-16'sd5000,   8'd175},
    {16'sd32767,  16'sd0,      8'd255},
    {16'h8000,    16'sd0,      8'd255},
    {16'sd30000,  16'sd30000,  8'd255},
    {16'h8000,    16'h8000,    8'd255},
    {16'sd25000,  16'sd15000,  8'd253},
    {16'sd127,    16'sd127,    8'd1},
    {-16'sd129,   16'sd1,      8'd1},
    {16'sd5000,  -16'sd3,      8'd39},
    {16'sd12345,  16'sd6789,   8'd122}
  };

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic signed [15:0] m_re [256];
  logic signed [15:0] m_im [256];
  logic               e_v [3];
  logic signed [15:0] e_i [3], e_q [3];
  string              e_t [3];
  logic signed [15:0] held_i, held_q;

  function automatic logic signed [15:0] rsat(input longint acc);
    longint r;
    r = (acc + 64'sd8192) >>> 14;
    if (r > 32767) return 16'sd32767;
    if (r < -32768) return 16'h8000;
    return r[15:0];
  endfunction

  task automatic model_reset();
    for (int a = 0; a < 256; a++) begin
      m_re[a] = 16'sd16384;
      m_im[a] = 16'sd0;
    end
    for (int k = 0; k < 3; k++) begin
      e_v[k] = 1'b0; e_i[k] = '0; e_q[k] = '0; e_t[k] = "R1";
    end
    held_i = '0;
    held_q = '0;
  endtask

  task automatic check_out();
    n_chk++;
    if (out_vld !== e_v[2] || out_i !== e_i[2] || out_q !== e_q[2]) begin
      n_bad++;
      $display("FAIL R2/%s: vld,i,q actual %0d,%0d,%0d expected %0d,%0d,%0d",
               e_t[2], out_vld, out_i, out_q, e_v[2], e_i[2], e_q[2]);
    end
  endtask

  // Called at a falling edge: check the sample from three drives ago, then drive a new one
  task automatic drive(input logic v, input logic signed [15:0] si, input logic signed [15:0] sq,
                       input logic [7:0] idx, input logic we, input logic [7:0] wa,
                       input logic signed [15:0] wr, input logic signed [15:0] wi,
                       input string tag);
    logic signed [15:0] xi, xq;
    check_out();
    if (we) begin
      m_re[wa] = wr;
      m_im[wa] = wi;
    end
    if (v) begin
      xi = rsat(longint'(si) * longint'(m_re[idx]) - longint'(sq) * longint'(m_im[idx]));
      xq = rsat(longint'(si) * longint'(m_im[idx]) + longint'(sq) * longint'(m_re[idx]));
      held_i = xi;
      held_q = xq;
    end else begin
      xi = held_i;
      xq = held_q;
    end
    for (int k = 2; k > 0; k--) begin
      e_v[k] = e_v[k-1]; e_i[k] = e_i[k-1]; e_q[k] = e_q[k-1]; e_t[k] = e_t[k-1];
    end
    e_v[0] = v; e_i[0] = xi; e_q[0] = xq; e_t[0] = tag;
    in_vld = v; in_i = si; in_q = sq;
    cf_we = we; cf_addr = wa; cf_re = wr; cf_im = wi;
    @(negedge clk);
  endtask

  task automatic drive_vec(input int n, input logic v, input string tag);
    drive(v, VEC[n][39:24], VEC[n][23:8], VEC[n][7:0], 1'b0, 8'd0, 16'sd0, 16'sd0, tag);
  endtask

  task automatic do_reset();
    rst = 1'b1; in_vld = 1'b0; cf_we = 1'b0;
    @(negedge clk);
    @(negedge clk);
    n_chk++;
    if (out_vld !== 1'b0 || out_i !== 16'sd0 || out_q !== 16'sd0) begin
      n_bad++;
      $display("FAIL R1: vld,i,q actual %0d,%0d,%0d expected 0,0,0", out_vld, out_i, out_q);
    end
    model_reset();
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();

    // R4: unloaded table behaves as unity gain
    for (int n = 0; n < 16; n++) drive_vec(n, 1'b1, "R4");

    // R7 / R6: fill every entry while samples stream, one write per cycle
    for (int a = 0; a < 256; a++) begin
      drive(1'b1, VEC[a % 16][39:24], VEC[a % 16][23:8], VEC[a % 16][7:0],
            1'b1, 8'(a), 16'(16384 - 32 * a), 16'(64 * a - 8192), "R7");
    end

    // R3 / R5: main vector walk over the loaded table
    for (int n = 0; n < 16; n++) drive_vec(n, 1'b1, "R3");

    // R8 / R2: gaps in the valid stream
    for (int n = 0; n < 16; n++) drive_vec(n, (n % 3) == 0, "R8");

    // R6: write to entry 31 in the cycle right after a sample of index 31
    drive_vec(3, 1'b1, "R6");
    drive(1'b1, 16'sd3000, 16'sd2000, 8'd31, 1'b1, 8'd31, -16'sd16384, 16'sd0, "R6");
    drive_vec(4, 1'b1, "R6");

    // R5: half-LSB rounding with gain 0.5 on entry 7
    drive(1'b0, 16'sd0, 16'sd0, 8'd0, 1'b1, 8'd7, 16'sd8192, 16'sd0, "R5");
    drive(1'b1, 16'sd1001, 16'sd0, 8'd7, 1'b0, 8'd0, 16'sd0, 16'sd0, "R5");
    drive(1'b1, -16'sd1001, 16'sd0, 8'd7, 1'b0, 8'd0, 16'sd0, 16'sd0, "R5");
    drive(1'b1, 16'sd0, 16'sd1001, 8'd7, 1'b0, 8'd0, 16'sd0, 16'sd0, "R5");

    // R5: output clamping with near-2.0 gains on the top entry
    drive(1'b0, 16'sd0, 16'sd0, 8'd0, 1'b1, 8'd255, 16'sd32767, 16'sd0, "R5");
    drive_vec(7, 1'b1, "R5");
    drive_vec(8, 1'b1, "R5");
    drive(1'b1, 16'sd0, 16'sd0, 8'd0, 1'b1, 8'd255, 16'sd0, 16'sd32767, "R5");
    drive_vec(9, 1'b1, "R5");
    drive_vec(10, 1'b1, "R5");
    for (int k = 0; k < 3; k++) drive_vec(0, 1'b0, "R2");

    // R1 / R4: reset mid-run returns the table to unity
    do_reset();
    for (int n = 0; n < 16; n++) drive_vec(n, 1'b1, "R4");
    for (int k = 0; k < 4; k++) drive_vec(0, 1'b0, "R2");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule